// File: doc/BRIEF.md
# Ring FIFO Token Controller

This block is the control slice that lets one small FIFO work as a single stage of a deeper FIFO. Several identical stages are wired in a ring: each stage's link output goes to the next stage's link input, and the last stage feeds the first. Two tokens travel around the ring. The write token marks the stage that accepts the next word, and the read token marks the stage that delivers the next word. A stage holding a token responds to the shared write or read strobe. All other stages stay idle. When a stage writes or reads its last local location, it drives its link output low for that cycle, and the token moves to the next stage at the following clock edge.

The block holds no storage. It drives the local write and read addresses and enables for a storage array beside it. It tracks local occupancy and drives per-stage full and empty contributions, which are ORed across the ring to form the ring-wide flags. When a stage sees its link input held low and its first-stage input high during reset, it runs alone. In that case it keeps both tokens, never pulses its link output, and additionally offers a half-full flag and a rewind of the read side.

Top module: `fifo_ring_token_ctrl`

## Requirements
- R1: While `rst_n` is low, a stage with `first_load_n` low takes both tokens and every other ring stage takes none. After reset only the first stage reports `empty_o` high, and every `xout_n` is high.
- R2: A stage that samples `xin_n` low and `first_load_n` high during reset runs alone. It holds both tokens and keeps `xout_n` high at all times.
- R3: `wr_en` is high only when `wr_req` is high, the stage holds the write token, and local occupancy is below DEPTH. A write to a full stage changes nothing. `wr_addr` steps 0,1,…,DEPTH-1 and then wraps to 0.
- R4: `rd_en` is high only when `rd_req` is high, the stage holds the read token, and local occupancy is nonzero. A read of an empty stage changes nothing. `rd_addr` wraps the same way as `wr_addr`.
- R5: In ring mode, `xout_n` is low in the cycle in which `wr_en` is high with `wr_addr` = DEPTH-1. The stage drops its write token at the next edge.
- R6: In ring mode, `xout_n` is low in the cycle in which `rd_en` is high with `rd_addr` = DEPTH-1. The stage drops its read token at the next edge.
- R7: Each clock edge that sees `xin_n` low counts as one hand-off. A ring stage assigns the hand-offs it receives alternately to the write token and then to the read token, starting with the write token after reset.
- R8: `full_o` is high exactly when the stage holds the write token and its occupancy equals DEPTH. `empty_o` is high exactly when the stage holds the read token and its occupancy is 0.
- R9: `half_o` is high when a standalone stage holds more than DEPTH/2 words. It is always low in ring mode.
- R10: In standalone mode, a low `rt_n` while both strobes are idle sets the read address to 0 and sets occupancy to the number of writes since reset, capped at DEPTH. In ring mode `rt_n` has no effect.
- R11: Words written across stage boundaries in a ring are read back in write order. At most one stage has `rd_en` high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| first_load_n | input | 1 | Low marks the stage that starts with both tokens |
| xin_n | input | 1 | Hand-off link from the previous stage, active low |
| rt_n | input | 1 | Read rewind request, active low, standalone only |
| wr_req | input | 1 | Shared write strobe |
| rd_req | input | 1 | Shared read strobe |
| wr_en | output | 1 | Local storage write enable |
| rd_en | output | 1 | Local storage read enable / data drive enable |
| wr_addr | output | $clog2(DEPTH) | Local write location |
| rd_addr | output | $clog2(DEPTH) | Local read location |
| xout_n | output | 1 | Hand-off link to the next stage, active low |
| full_o | output | 1 | Contribution to the ring-wide full flag |
| empty_o | output | 1 | Contribution to the ring-wide empty flag |
| half_o | output | 1 | More than half occupied, standalone only |

## Verification
The write hand-off of one stage can occur in the same cycle as a read served by another stage, and one stage can receive a token on its link while it is itself reading. The bench provokes both overlaps by asserting `wr_req` and `rd_req` together for a run of cycles, with the read side one word behind the write side across a three-stage ring. Each such cycle is judged on three things: which stage enables the write, which single stage enables the read and the data it returns, and the exact set of `xout_n` lines that are low.

// File: rtl/fifo_ring_token_ctrl.sv
module fifo_ring_token_ctrl #(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       first_load_n,
  input  logic                       xin_n,
  input  logic                       rt_n,
  input  logic                       wr_req,
  input  logic                       rd_req,
  output logic                       wr_en,
  output logic                       rd_en,
  output logic [$clog2(DEPTH)-1:0]   wr_addr,
  output logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic                       xout_n,
  output logic                       full_o,
  output logic                       empty_o,
  output logic                       half_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          alone, wtok, rtok, nxt_w;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, wtot;

  wire loc_full  = (cnt == CW'(DEPTH));
  wire loc_empty = (cnt == '0);
  wire rewind    = alone & ~rt_n;

  assign wr_en   = wr_req & wtok & ~loc_full;
  assign rd_en   = rd_req & rtok & ~loc_empty & ~rewind;
  assign wr_addr = wptr;
  assign rd_addr = rptr;

  wire pass_w = wr_en & (wptr == LAST) & ~alone;
  wire pass_r = rd_en & (rptr == LAST) & ~alone;
  assign xout_n  = ~(pass_w | pass_r);

  assign full_o  = wtok & loc_full;
  assign empty_o = rtok & loc_empty;
  assign half_o  = alone & (cnt > CW'(DEPTH / 2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alone <= ~xin_n & first_load_n;
      wtok  <= ~first_load_n | ~xin_n;
      rtok  <= ~first_load_n | ~xin_n;
      nxt_w <= 1'b1;
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      wtot  <= '0;
    end else begin
      if (wr_en) begin
        wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
        if (wtot != CW'(DEPTH)) wtot <= wtot + 1'b1;
      end
      if (rewind) begin
        rptr <= '0;
        cnt  <= wtot;
      end else begin
        if (rd_en) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        cnt <= cnt + CW'(wr_en) - CW'(rd_en);
      end
      if (pass_w) wtok <= 1'b0;
      if (pass_r) rtok <= 1'b0;
      if (!alone && !xin_n) begin
        if (nxt_w) wtok <= 1'b1;
        else       rtok <= 1'b1;
        nxt_w <= ~nxt_w;
      end
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_standalone_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alone |-> (xout_n && wtok && rtok));
  assert_wtok_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pass_w |=> !wtok);
  assert_rtok_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_r |=> !rtok);
  assert_token_via_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!alone && $rose(wtok)) |-> $past(!xin_n));
  assert_no_half_in_ring_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !alone |-> !half_o);
endmodule

// File: tb/fifo_ring_token_ctrl_bench.sv
module fifo_ring_token_ctrl_bench;
  localparam int DEPTH = 4;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  int wi = 0, ri = 0;

  logic wr_req = 0, rd_req = 0, rt_n = 1;
  logic [7:0] wdata = '0;
  logic [N-1:0] wen, ren, xo, fullv, emptv, halfv;
  logic [1:0] wa [N];
  logic [1:0] ra [N];
  logic [7:0] mem [N][DEPTH];
  logic [7:0] rdata;

  for (genvar gi = 0; gi < N; gi++) begin : g_ring
    fifo_ring_token_ctrl #(.DEPTH(DEPTH)) u_fifo_ring_token_ctrl (
      .clk(clk), .rst_n(rst_n), .first_load_n(gi != 0),
      .xin_n(xo[(gi + N - 1) % N]), .rt_n(rt_n),
      .wr_req(wr_req), .rd_req(rd_req),
      .wr_en(wen[gi]), .rd_en(ren[gi]), .wr_addr(wa[gi]), .rd_addr(ra[gi]),
      .xout_n(xo[gi]), .full_o(fullv[gi]), .empty_o(emptv[gi]), .half_o(halfv[gi]));
  end

  always @(posedge clk)
    for (int k = 0; k < N; k++) if (wen[k]) mem[k][wa[k]] <= wdata;

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N; k++) if (ren[k]) rdata = mem[k][ra[k]];
  end

  logic s_wr = 0, s_rd = 0, s_rt = 1;
  logic s_wen, s_ren, s_xo, s_full, s_emp, s_half;
  logic [1:0] s_wa, s_ra;
  logic [7:0] s_mem [DEPTH];
  bit s_xo_seen = 0;

  fifo_ring_token_ctrl #(.DEPTH(DEPTH)) u_fifo_ring_token_ctrl (
    .clk(clk), .rst_n(rst_n), .first_load_n(1'b1), .xin_n(1'b0), .rt_n(s_rt),
    .wr_req(s_wr), .rd_req(s_rd), .wr_en(s_wen), .rd_en(s_ren),
    .wr_addr(s_wa), .rd_addr(s_ra), .xout_n(s_xo), .full_o(s_full),
    .empty_o(s_emp), .half_o(s_half));

  always @(posedge clk) begin
    if (s_wen) s_mem[s_wa] <= wdata;
    if (rst_n && !s_xo) s_xo_seen = 1;
  end

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 8'h21);
  endfunction

  function automatic int who(logic [N-1:0] v);
    int r = -1;
    if ($countones(v) > 1) return 9;
    for (int k = 0; k < N; k++) if (v[k]) r = k;
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ring_step(bit do_w, bit do_r, string req);
    logic [N-1:0] exp_xo = '1;
    @(negedge clk);
    wr_req = do_w; rd_req = do_r; wdata = pat(wi);
    #1;
    chk({req, " write stage"}, who(wen), do_w ? (wi / DEPTH) % N : -1);
    chk({req, " read stage R11"}, who(ren), do_r ? (ri / DEPTH) % N : -1);
    if (do_r) chk({req, " read data R11"}, rdata, pat(ri));
    if (do_w && wi % DEPTH == DEPTH - 1) exp_xo[(wi / DEPTH) % N] = 1'b0;
    if (do_r && ri % DEPTH == DEPTH - 1) exp_xo[(ri / DEPTH) % N] = 1'b0;
    chk({req, " link R5 R6"}, xo, exp_xo);
    @(posedge clk); #1;
    wr_req = 0; rd_req = 0;
    if (do_w) wi++;
    if (do_r) ri++;
  endtask

  task automatic t_ring_reset;
    #1;
    chk("R1 empty contributions", emptv, 3'b001);
    chk("R1 full contributions", fullv, 3'b000);
    chk("R1 link idle", xo, 3'b111);
  endtask

  task automatic t_ring_fill;
    for (int i = 0; i < N * DEPTH; i++) ring_step(1, 0, "R3 R7 fill");
    chk("R8 ring full", fullv, 3'b001);
    chk("R9 half off in ring", halfv, 3'b000);
    @(negedge clk); wr_req = 1; #1;
    chk("R3 write to full ignored", who(wen), -1);
    @(posedge clk); #1; wr_req = 0;
  endtask

  task automatic t_ring_drain;
    for (int i = 0; i < N * DEPTH; i++) ring_step(0, 1, "R4 R7 drain");
    chk("R8 ring empty", emptv, 3'b001);
    @(negedge clk); rd_req = 1; #1;
    chk("R4 read of empty ignored", who(ren), -1);
    @(posedge clk); #1; rd_req = 0;
  endtask

  task automatic t_ring_interleave;
    for (int i = 0; i < 10; i++) begin
      ring_step(1, 0, "R3 interleave");
      ring_step(0, 1, "R4 interleave");
    end
  endtask

  task automatic t_ring_concurrent;
    ring_step(1, 0, "R5 overlap lead");
    for (int i = 0; i < 9; i++) ring_step(1, 1, "R5 R6 overlap");
  endtask

  task automatic t_ring_rewind;
    @(negedge clk); rt_n = 0;
    @(posedge clk); #1; rt_n = 1;
    ring_step(0, 1, "R10 rewind ignored in ring");
    chk("R8 empty after rewind", emptv[(ri / DEPTH) % N], 1);
  endtask

  task automatic s_op(bit w, bit r, logic [7:0] d);
    @(negedge clk); s_wr = w; s_rd = r; wdata = d; #1;
  endtask

  task automatic s_end;
    @(posedge clk); #1; s_wr = 0; s_rd = 0;
  endtask

  task automatic t_standalone;
    #1;
    chk("R2 standalone link idle", s_xo, 1);
    chk("R2 standalone empty flag", s_emp, 1);
    for (int i = 0; i < DEPTH; i++) begin
      s_op(1, 0, pat(100 + i));
      chk("R3 standalone write", s_wen, 1);
      chk("R3 standalone address", s_wa, i);
      s_end;
      chk("R9 half flag", s_half, (i + 1) > DEPTH / 2);
    end
    chk("R8 standalone full", s_full, 1);
    s_op(1, 0, 8'hEE);
    chk("R3 standalone write to full", s_wen, 0);
    s_end;
    for (int i = 0; i < 2; i++) begin
      s_op(0, 1, 0);
      chk("R4 standalone read", s_ren, 1);
      chk("R4 standalone data", s_mem[s_ra], pat(100 + i));
      s_end;
    end
    @(negedge clk); s_rt = 0;
    @(posedge clk); #1; s_rt = 1;
    chk("R10 rewind occupancy via full", s_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      s_op(0, 1, 0);
      chk("R10 replay address", s_ra, i);
      chk("R10 replay data", s_mem[s_ra], pat(100 + i));
      s_end;
    end
    s_op(0, 1, 0);
    chk("R4 standalone read of empty", s_ren, 0);
    s_end;
    chk("R2 link never pulsed", s_xo_seen, 0);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_ring_reset;
    t_standalone;
    t_ring_fill;
    t_ring_drain;
    t_ring_interleave;
    t_ring_concurrent;
    t_ring_rewind;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule